// File: doc/BRIEF.md
# Two-Pass Streaming Hole Filler

This block fills enclosed holes in a binary image. Pixels arrive four per clock in raster order. While a frame streams in, the block runs the first mask pass on the fly and stores each group's input bits and pass-one mask in one half of a ping-pong buffer. When the frame is complete, a second pass sweeps that buffer in reverse raster order, updates the mask in place and streams the result out, four pixels per clock. The next frame fills the other half of the buffer at the same time.

The mask begins with 0 on the image border and 1 everywhere else. On each visit to an interior pixel, the mask bit clears when the input pixel is 0 and any of the four edge-adjacent mask bits is 0. Otherwise the bit keeps its value. The first pass runs left to right and top to bottom. The second pass runs right to left and bottom to top, starting from the first pass's result. In each pass, neighbours already visited supply their value from the current pass. Neighbours not yet visited supply the value they held before the pass began.

Inside a four-pixel group each pixel depends on the one before it in scan order. Each lane therefore computes two candidate results, one assuming the predecessor cleared and one assuming it did not. A select chain then picks the correct candidate, so one group retires every cycle.

Top module: `hole_fill2p`

Two state machines run the block:

- The fill machine has the states FILL_OPEN and FILL_HOLD.
  - FILL_OPEN moves to FILL_HOLD when the last word of a frame is accepted.
  - FILL_HOLD moves back to FILL_OPEN once the next buffer half is empty.
- The sweep machine has the states SWEEP_IDLE and SWEEP_RUN.
  - SWEEP_IDLE moves to SWEEP_RUN when its buffer half holds a complete frame.
  - SWEEP_RUN moves back to SWEEP_IDLE after it emits buffer word 0.

## Requirements
- R1: After reset, `out_valid` and `out_last` are 0 and `in_ready` is 1 (fill machine in FILL_OPEN).
- R2: Every output pixel on the first or last row or column of the image is 0, whatever the input there.
- R3: An interior input pixel of 0 whose 0-mask neighbour is reachable as defined by the two-pass rule comes out as 0. An input pixel of 1 inside the image comes out as 1.
- R4: A region of 0 input pixels enclosed by a closed 4-connected foreground outline that no border-connected 0 reaches comes out as 1 (filled).
- R5: The output equals a sequential model of the same two passes. Pass one runs left to right and top to bottom, with left and up neighbours taken from pass one and right and down neighbours from the initial mask. Pass two runs right to left and bottom to top, with right and down neighbours taken from pass two and left and up neighbours from pass one. Paths that need more than these two sweeps stay 1.
- R6: The candidate select entering the first group of each row is forced to 1, so a group's result never depends on the previous row's last group. Narrow frames of two groups per row match the model.
- R7: Output words leave in reverse raster order: last row first and, within a row, the rightmost group first. Bit k of `out_data` is column 4*g+k of group g. `out_last` is 1 exactly on the word holding column 0 of row 0.
- R8: When a buffer half is free, `in_ready` stays 1 for a whole frame, so a frame of N words with `in_valid` held high is accepted in N consecutive cycles. A frame's output words are emitted on consecutive cycles.
- R9: A new frame starts being accepted before the previous frame's last output word, because the two passes work on separate buffer halves.
- R10: Each frame produces exactly (width/4)*height output words.
- R11: Width is a multiple of 4 from 8 to MAX_W and height is from 3 to MAX_H. Configuration holds while any frame is in flight, and every legal size is processed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | $clog2(MAX_W+1) | Image width in pixels |
| cfg_height | input | $clog2(MAX_H+1) | Image height in rows |
| in_valid | input | 1 | Input group present |
| in_ready | output | 1 | Block accepts a group this cycle |
| in_data | input | LANES | Four input pixels, bit k = leftmost column + k |
| out_valid | output | 1 | Output group present |
| out_data | output | LANES | Four filled pixels, bit k = group column + k |
| out_last | output | 1 | Final word of a frame (top-left group) |

## Verification
The checker assumes the configuration stays unchanged from a frame's first accepted word until that frame's last output word. It also assumes every accepted frame is exactly (width/4)*height words long. The bench changes the size only after it has drained all expected output, and it drives exactly one frame's worth of words per call. Given those inputs, the checker relies on output bursts being contiguous and on the top-left word always being zero.

// File: rtl/hf_pkg.sv
package hf_pkg;
    typedef enum logic {FILL_OPEN, FILL_HOLD}   fill_st_e;
    typedef enum logic {SWEEP_IDLE, SWEEP_RUN}  sweep_st_e;
endpackage

// File: rtl/hf_group.sv
// Carry-select evaluation of one group: every lane computes the result for
// both possible predecessor values, then a select chain picks the true one.
module hf_group #(
    parameter int LANES = 4
) (
    input  logic             cin,
    input  logic [LANES-1:0] px,
    input  logic [LANES-1:0] old_m,
    input  logic [LANES-1:0] oth_z,
    input  logic [LANES-1:0] brd,
    output logic [LANES-1:0] res
);
    logic [LANES-1:0] cand0;
    logic [LANES-1:0] cand1;
    logic [LANES:0]   sel;

    assign sel[0] = cin;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // predecessor cleared: a zero input pixel always clears
        assign cand0[k] = !brd[k] && px[k] && old_m[k];
        // predecessor kept: only the other neighbours can clear
        assign cand1[k] = !brd[k] && old_m[k] && (px[k] || !oth_z[k]);
        assign res[k]   = sel[k] ? cand1[k] : cand0[k];
        assign sel[k+1] = res[k];
    end
endmodule

// File: rtl/hf_store.sv
// Ping-pong frame store: input bits and mask bits, one word per group.
module hf_store #(
    parameter int LANES = 4,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             wa_en,
    input  logic             wa_bank,
    input  logic [AW-1:0]    wa_addr,
    input  logic [LANES-1:0] wa_img,
    input  logic [LANES-1:0] wa_msk,
    input  logic             wb_en,
    input  logic             wb_bank,
    input  logic [AW-1:0]    wb_addr,
    input  logic [LANES-1:0] wb_msk,
    input  logic [AW-1:0]    ra_up,
    output logic [LANES-1:0] ra_up_msk,
    input  logic [AW-1:0]    rb_cur,
    input  logic [AW-1:0]    rb_left,
    input  logic [AW-1:0]    rb_up,
    input  logic [AW-1:0]    rb_dn,
    output logic [LANES-1:0] rb_img,
    output logic [LANES-1:0] rb_msk,
    output logic             rb_left_bit,
    output logic [LANES-1:0] rb_up_msk,
    output logic [LANES-1:0] rb_dn_msk
);
    localparam int DEPTH = 1 << AW;

    logic [LANES-1:0] img_q [2*DEPTH];
    logic [LANES-1:0] msk_q [2*DEPTH];
    logic [LANES-1:0] left_w;

    always_ff @(posedge clk) begin
        if (wa_en) begin
            img_q[{wa_bank, wa_addr}] <= wa_img;
            msk_q[{wa_bank, wa_addr}] <= wa_msk;
        end
        if (wb_en) begin
            msk_q[{wb_bank, wb_addr}] <= wb_msk;
        end
    end

    assign ra_up_msk   = msk_q[{wa_bank, ra_up}];
    assign rb_img      = img_q[{wb_bank, rb_cur}];
    assign rb_msk      = msk_q[{wb_bank, rb_cur}];
    assign left_w      = msk_q[{wb_bank, rb_left}];
    assign rb_left_bit = left_w[LANES-1];
    assign rb_up_msk   = msk_q[{wb_bank, rb_up}];
    assign rb_dn_msk   = msk_q[{wb_bank, rb_dn}];
endmodule

// File: rtl/hf_ctrl.sv
// Fill and sweep state machines with their scan counters and bank flags.
module hf_ctrl
    import hf_pkg::*;
#(
    parameter int LANES = 4,
    parameter int WW    = 6,
    parameter int HW    = 6,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [WW-1:0] cfg_width,
    input  logic [HW-1:0] cfg_height,
    input  logic          in_valid,
    output logic          in_ready,
    output logic          f_go,
    output logic          f_bank,
    output logic          f_first,
    output logic [WW-1:0] f_col,
    output logic [HW-1:0] f_row,
    output logic [AW-1:0] f_addr,
    output logic          s_go,
    output logic          s_bank,
    output logic          s_first,
    output logic          s_last,
    output logic [WW-1:0] s_col,
    output logic [HW-1:0] s_row,
    output logic [AW-1:0] s_addr
);
    localparam int LG = $clog2(LANES);

    fill_st_e  fst_q, fst_d;
    sweep_st_e sst_q, sst_d;
    logic [1:0]    full_q;
    logic          f_bank_q, s_bank_q, s_start, f_end;
    logic [WW-1:0] f_col_q, s_col_q, last_col;
    logic [HW-1:0] f_row_q, s_row_q, last_row;
    logic [AW-1:0] f_addr_q, s_addr_q;
    logic [AW:0]   nwords;

    assign last_col = cfg_width - WW'(LANES);
    assign last_row = cfg_height - HW'(1);
    assign nwords   = (AW+1)'(cfg_width >> LG) * (AW+1)'(cfg_height);
    assign f_end    = (f_col_q == last_col) && (f_row_q == last_row);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fst_q <= FILL_OPEN;
            sst_q <= SWEEP_IDLE;
        end else begin
            fst_q <= fst_d;
            sst_q <= sst_d;
        end
    end

    // next state and outputs
    always_comb begin
        fst_d    = fst_q;
        sst_d    = sst_q;
        in_ready = 1'b0;
        f_go     = 1'b0;
        s_go     = 1'b0;
        s_start  = 1'b0;
        unique case (fst_q)
            FILL_OPEN: begin
                in_ready = 1'b1;
                f_go     = in_valid;
                if (in_valid && f_end) fst_d = FILL_HOLD;
            end
            FILL_HOLD: begin
                if (!full_q[f_bank_q]) fst_d = FILL_OPEN;
            end
        endcase
        unique case (sst_q)
            SWEEP_IDLE: begin
                if (full_q[s_bank_q]) begin
                    s_start = 1'b1;
                    sst_d   = SWEEP_RUN;
                end
            end
            SWEEP_RUN: begin
                s_go = 1'b1;
                if (s_addr_q == '0) sst_d = SWEEP_IDLE;
            end
        endcase
    end

    assign s_last  = s_go && (s_addr_q == '0);
    assign f_first = (f_col_q == '0);
    assign s_first = (s_col_q == last_col);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_col_q  <= '0;
            f_row_q  <= '0;
            f_addr_q <= '0;
            f_bank_q <= 1'b0;
        end else if (f_go) begin
            f_addr_q <= f_end ? '0 : f_addr_q + AW'(1);
            if (f_col_q == last_col) begin
                f_col_q <= '0;
                f_row_q <= f_end ? '0 : f_row_q + HW'(1);
            end else begin
                f_col_q <= f_col_q + WW'(LANES);
            end
            if (f_end) f_bank_q <= ~f_bank_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_col_q  <= '0;
            s_row_q  <= '0;
            s_addr_q <= '0;
            s_bank_q <= 1'b0;
        end else if (s_start) begin
            s_col_q  <= last_col;
            s_row_q  <= last_row;
            s_addr_q <= AW'(nwords - (AW+1)'(1));
        end else if (s_go) begin
            s_addr_q <= s_addr_q - AW'(1);
            if (s_col_q == '0) begin
                s_col_q <= last_col;
                s_row_q <= s_row_q - HW'(1);
            end else begin
                s_col_q <= s_col_q - WW'(LANES);
            end
            if (s_last) s_bank_q <= ~s_bank_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= '0;
        end else begin
            if (f_go && f_end) full_q[f_bank_q] <= 1'b1;
            if (s_last)        full_q[s_bank_q] <= 1'b0;
        end
    end

    assign f_bank = f_bank_q;
    assign f_col  = f_col_q;
    assign f_row  = f_row_q;
    assign f_addr = f_addr_q;
    assign s_bank = s_bank_q;
    assign s_col  = s_col_q;
    assign s_row  = s_row_q;
    assign s_addr = s_addr_q;
endmodule

// File: rtl/hole_fill2p.sv
module hole_fill2p #(
    parameter int MAX_W = 32,
    parameter int MAX_H = 32,
    parameter int LANES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(MAX_W+1)-1:0]   cfg_width,
    input  logic [$clog2(MAX_H+1)-1:0]   cfg_height,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [LANES-1:0]             in_data,
    output logic                         out_valid,
    output logic [LANES-1:0]             out_data,
    output logic                         out_last
);
    localparam int LG = $clog2(LANES);
    localparam int WW = $clog2(MAX_W+1);
    localparam int HW = $clog2(MAX_H+1);
    localparam int AW = $clog2(MAX_W / LANES * MAX_H);

    logic          f_go, f_bank, f_first, s_go, s_bank, s_first, s_last;
    logic [WW-1:0] f_col, s_col, w_m1;
    logic [HW-1:0] f_row, s_row, h_m1;
    logic [AW-1:0] f_addr, s_addr, wpr;

    assign w_m1 = cfg_width - WW'(1);
    assign h_m1 = cfg_height - HW'(1);
    assign wpr  = AW'(cfg_width >> LG);

    hf_ctrl #(.LANES(LANES), .WW(WW), .HW(HW), .AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .in_valid(in_valid), .in_ready(in_ready),
        .f_go(f_go), .f_bank(f_bank), .f_first(f_first),
        .f_col(f_col), .f_row(f_row), .f_addr(f_addr),
        .s_go(s_go), .s_bank(s_bank), .s_first(s_first), .s_last(s_last),
        .s_col(s_col), .s_row(s_row), .s_addr(s_addr)
    );

    logic [LANES-1:0] up1, p1_brd, p1_oz, p1_res;
    logic [LANES-1:0] c_img, c_msk, up2, dn2;
    logic             left_bit;
    logic [LANES-1:0] p2_px, p2_old, p2_oz, p2_brd, p2_res_c, p2_res;
    logic             p1_carry_q, p2_carry_q;

    hf_store #(.LANES(LANES), .AW(AW)) u_store (
        .clk(clk),
        .wa_en(f_go), .wa_bank(f_bank), .wa_addr(f_addr), .wa_img(in_data), .wa_msk(p1_res),
        .wb_en(s_go), .wb_bank(s_bank), .wb_addr(s_addr), .wb_msk(p2_res),
        .ra_up(f_addr - wpr), .ra_up_msk(up1),
        .rb_cur(s_addr), .rb_left(s_addr - AW'(1)), .rb_up(s_addr - wpr),
        .rb_dn(s_addr + wpr),
        .rb_img(c_img), .rb_msk(c_msk), .rb_left_bit(left_bit),
        .rb_up_msk(up2), .rb_dn_msk(dn2)
    );

    // pass one: raster order, chain runs from lane 0 up
    for (genvar k = 0; k < LANES; k++) begin : g_p1
        logic [WW-1:0] col;
        assign col       = f_col + WW'(k);
        assign p1_brd[k] = (col == '0) || (col == w_m1) || (f_row == '0) || (f_row == h_m1);
        assign p1_oz[k]  = !up1[k] || (col + WW'(1) == w_m1) || (f_row + HW'(1) == h_m1);
    end

    hf_group #(.LANES(LANES)) u_grp1 (
        .cin(f_first ? 1'b1 : p1_carry_q), .px(in_data), .old_m({LANES{1'b1}}),
        .oth_z(p1_oz), .brd(p1_brd), .res(p1_res)
    );

    // pass two: anti-raster order, chain runs from the top lane down
    for (genvar k = 0; k < LANES; k++) begin : g_p2
        logic [WW-1:0] col;
        logic          lft;
        assign col = s_col + WW'(k);
        if (k == 0) begin : g_edge
            assign lft = left_bit;
        end else begin : g_in
            assign lft = c_msk[k-1];
        end
        assign p2_px[LANES-1-k]  = c_img[k];
        assign p2_old[LANES-1-k] = c_msk[k];
        assign p2_oz[LANES-1-k]  = !lft || !up2[k] || !dn2[k];
        assign p2_brd[LANES-1-k] = (col == '0) || (col == w_m1) || (s_row == '0) || (s_row == h_m1);
        assign p2_res[k]         = p2_res_c[LANES-1-k];
    end

    hf_group #(.LANES(LANES)) u_grp2 (
        .cin(s_first ? 1'b1 : p2_carry_q), .px(p2_px), .old_m(p2_old),
        .oth_z(p2_oz), .brd(p2_brd), .res(p2_res_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p1_carry_q <= 1'b1;
            p2_carry_q <= 1'b1;
            out_valid  <= 1'b0;
            out_last   <= 1'b0;
            out_data   <= '0;
        end else begin
            if (f_go) p1_carry_q <= p1_res[LANES-1];
            if (s_go) p2_carry_q <= p2_res[0];
            out_valid <= s_go;
            out_last  <= s_last;
            if (s_go) out_data <= p2_res;
        end
    end
endmodule

// File: rtl/hf_chk.sv
module hf_chk #(
    parameter int LANES = 4,
    parameter int WW    = 6,
    parameter int HW    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WW-1:0]    cfg_width,
    input logic [HW-1:0]    cfg_height,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic [LANES-1:0] out_data,
    input logic             out_last
);
    localparam int LG = $clog2(LANES);

    logic [31:0] in_cnt, out_cnt, pending, fwords;
    logic        in_done, busy;

    assign fwords  = 32'(cfg_width >> LG) * 32'(cfg_height);
    assign in_done = in_valid && in_ready && (in_cnt == fwords - 32'd1);
    assign busy    = (in_cnt != 32'd0) || (pending != 32'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_cnt  <= '0;
            out_cnt <= '0;
            pending <= '0;
        end else begin
            if (in_valid && in_ready) in_cnt <= in_done ? 32'd0 : in_cnt + 32'd1;
            if (out_valid) out_cnt <= out_last ? 32'd0 : out_cnt + 32'd1;
            pending <= pending + (in_done ? 32'd1 : 32'd0) - ((out_valid && out_last) ? 32'd1 : 32'd0);
        end
    end

    // R2
    top_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_data == '0);
    // R7
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    // R8
    burst_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);
    // R10
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> out_cnt == fwords - 32'd1);
    // R9
    out_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> pending != 32'd0);
    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($stable(cfg_width) && $stable(cfg_height)));
endmodule

bind hole_fill2p hf_chk #(.LANES(LANES), .WW(WW), .HW(HW)) u_hf_chk (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last)
);

// File: tb/test_hole_fill2p.sv
module test_hole_fill2p;
    localparam int CLK_NS = 10;
    localparam int MAX_W  = 32;
    localparam int MAX_H  = 32;
    localparam int LANES  = 4;
    localparam int WW     = $clog2(MAX_W+1);
    localparam int HW     = $clog2(MAX_H+1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [WW-1:0] cfg_width = WW'(16);
    logic [HW-1:0] cfg_height = HW'(8);
    logic in_valid = 1'b0;
    logic in_ready;
    logic [LANES-1:0] in_data = '0;
    logic out_valid, out_last;
    logic [LANES-1:0] out_data;

    hole_fill2p #(.MAX_W(MAX_W), .MAX_H(MAX_H), .LANES(LANES)) i_hole_fill2p (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

    always #(CLK_NS/2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;
    bit img [MAX_H][MAX_W];
    bit mdl [MAX_H][MAX_W];
    logic [LANES-1:0] exp_d[$];
    bit               exp_l[$];
    string            exp_t[$];
    int               exp_n[$];
    int               last_t[$];
    int               words_seen = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, expv);
        end
    endtask

    function automatic bit is_brd(int r, int c, int w, int h);
        return (r == 0) || (c == 0) || (r == h-1) || (c == w-1);
    endfunction

    function automatic void visit(int r, int c, int w, int h);
        if (!is_brd(r, c, w, h) && !img[r][c] &&
            (!mdl[r][c-1] || !mdl[r][c+1] || !mdl[r-1][c] || !mdl[r+1][c]))
            mdl[r][c] = 0;
    endfunction

    function automatic void run_model(int w, int h);
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++) mdl[r][c] = !is_brd(r, c, w, h);
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++) visit(r, c, w, h);
        for (int r = h-1; r >= 0; r--)
            for (int c = w-1; c >= 0; c--) visit(r, c, w, h);
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            words_seen++;
            if (exp_d.size() == 0) begin
                check(0, "R10", "unexpected word", int'(out_data), 0);
            end else begin
                logic [LANES-1:0] ed;
                bit el;
                string et;
                ed = exp_d.pop_front();
                el = exp_l.pop_front();
                et = exp_t.pop_front();
                check(out_data == ed, et, "data", int'(out_data), int'(ed));
                check(out_last == el, "R7", "last flag", int'(out_last), int'(el));
            end
            if (out_last) begin
                int en;
                en = (exp_n.size() != 0) ? exp_n.pop_front() : -1;
                check(words_seen == en, "R10", "words per frame", words_seen, en);
                words_seen = 0;
                last_t.push_back(cyc);
            end
        end
    end

    task automatic send_frame(int w, int h, string tag, bit gaps, output int t0, output int t1);
        run_model(w, h);
        cfg_width  = WW'(w);
        cfg_height = HW'(h);
        exp_n.push_back(w / LANES * h);
        for (int r = h-1; r >= 0; r--)
            for (int g = w/LANES-1; g >= 0; g--) begin
                logic [LANES-1:0] wd;
                for (int k = 0; k < LANES; k++) wd[k] = mdl[r][g*LANES+k];
                exp_d.push_back(wd);
                exp_l.push_back(r == 0 && g == 0);
                exp_t.push_back(tag);
            end
        t0 = -1;
        t1 = -1;
        for (int r = 0; r < h; r++)
            for (int g = 0; g < w/LANES; g++) begin
                if (gaps && $urandom_range(3) == 0) begin
                    in_valid = 1'b0;
                    @(negedge clk);
                end
                in_valid = 1'b1;
                for (int k = 0; k < LANES; k++) in_data[k] = img[r][g*LANES+k];
                while (!in_ready) @(negedge clk);
                if (t0 < 0) t0 = cyc;
                t1 = cyc;
                @(negedge clk);
            end
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_d.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic fill_const(bit v);
        for (int r = 0; r < MAX_H; r++)
            for (int c = 0; c < MAX_W; c++) img[r][c] = v;
    endtask

    task automatic outline(int r0, int c0, int r1, int c1);
        for (int c = c0; c <= c1; c++) begin img[r0][c] = 1; img[r1][c] = 1; end
        for (int r = r0; r <= r1; r++) begin img[r][c0] = 1; img[r][c1] = 1; end
        for (int r = r0+1; r < r1; r++)
            for (int c = c0+1; c < c1; c++) img[r][c] = 0;
    endtask

    task automatic random_img(int w, int h);
        fill_const(0);
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++) img[r][c] = ($urandom_range(3) == 0);
        if (w >= 12 && h >= 8) begin
            outline(1, 2, h/2, w/2);
            outline(h/2, w/2 + 1, h-2, w-2);
        end
    endtask

    initial begin
        repeat (LIMIT_CYC()) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R8 watchdog act=%0d exp=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    function automatic int LIMIT_CYC();
        return 150000;
    endfunction

    initial begin
        int a0, a1, b0, b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0 && out_last == 1'b0, "R1", "outputs idle", int'(out_valid), 0);

        // R3: all background clears entirely
        fill_const(0);
        send_frame(16, 8, "R3", 1, a0, a1);
        drain();
        // R2: all foreground keeps interior, border zero
        fill_const(1);
        send_frame(16, 8, "R2", 1, a0, a1);
        drain();
        // R4: closed outline with a zero interior is filled
        fill_const(0);
        outline(2, 3, 9, 18);
        send_frame(24, 12, "R4", 0, a0, a1);
        drain();
        // R5: box opened on its lower side needs the reverse pass; serpentine stays partly
        fill_const(0);
        outline(2, 2, 8, 16);
        img[8][9] = 0;
        for (int c = 1; c < 19; c++) if (c != 17) img[10][c] = 1;
        for (int c = 2; c < 19; c++) img[12][c] = 1;
        send_frame(20, 15, "R5", 1, a0, a1);
        drain();
        // R6: two groups per row
        random_img(8, 6);
        send_frame(8, 6, "R6", 1, a0, a1);
        drain();
        // R11: several sizes
        random_img(32, 32);
        send_frame(32, 32, "R11", 1, a0, a1);
        drain();
        random_img(12, 5);
        send_frame(12, 5, "R11", 0, a0, a1);
        drain();
        random_img(28, 3);
        send_frame(28, 3, "R11", 1, a0, a1);
        drain();
        // R8, R9: back-to-back frames of equal size
        last_t.delete();
        random_img(16, 16);
        send_frame(16, 16, "R9", 0, a0, a1);
        random_img(16, 16);
        send_frame(16, 16, "R9", 0, b0, b1);
        drain();
        check(a1 - a0 == 16/LANES*16 - 1, "R8", "accept cycles for a frame", a1 - a0, 16/LANES*16 - 1);
        check(last_t.size() == 2 && b0 < last_t[0], "R9", "second frame starts before first ends",
              b0, (last_t.size() != 0) ? last_t[0] : -1);
        check(exp_d.size() == 0, "R10", "all expected words seen", exp_d.size(), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule